// File: doc/BRIEF.md
# Crosspoint Output Cell

This block is one output cell of a configurable digital crosspoint switch. A static configuration word names four candidate nets out of a shared bank of I/O nets. Two select inputs then pick one of those four on every cycle. The chosen bit can pass straight to the pin, be held in a level-sensitive store, or be captured on a clock edge. The result drives a pin that has a separate drive-enable output. Each of the five per-cell control inputs (output enable, storage clock, clock enable and the two selects) has its own polarity bit. A fixed-level mode ties the pin to a configured constant.

Four neighbouring cells can be chained into a 16:1 selector. Each cell exposes its registered local 4:1 result, and an expanding cell picks among its own result and three neighbour results. The storage clock and the clock enable can each come from a per-cell control input or from one of the global clock lines. Those global lines double as enable sources.

The cell runs on one system clock. The storage clock and enable are sampled levels in that domain, so a "rising edge" means the sampled effective clock went from 0 to 1 between consecutive cycles. Both pin outputs are registered.

Top module: `xpt_out_cell`

## Requirements
- R1: A synchronous active-high `rst` clears the configuration, the stored bit, `local_sel_o`, `pin_o` and `pin_en_o` to 0.
- R2: Until the first `cfg_we` pulse after reset, `pin_en_o` stays 0 whatever `oe_in` does.
- R3: With the default 16 nets, the configuration word has the following fields:
  - bits [4k+3:4k] hold the net index of source k (k = 0..3);
  - bits [20:16] are the polarity bits for output enable, storage clock, clock enable, select 0 and select 1, in that order from bit 16;
  - bits [22:21] are the storage mode: 0 combinational, 1 latch, 2 or 3 register;
  - bit 23 enables fixed level and bit 24 is that level;
  - bits [27:25] are the clock source and bits [30:28] the enable source;
  - bit 31 enables the expander.
- R4: In combinational mode without the expander, `pin_o` one cycle after the inputs equals `net_in` at the index of source {eff sel1, eff sel0}, and it can change on every cycle.
- R5: Every control input takes effect as the input XOR its polarity bit, so a set bit makes that control active-low.
- R6: Once configured, `pin_en_o` one cycle later equals the effective output enable.
- R7: In latch mode, the stored bit follows the selected data while the effective clock and effective enable are both 1, and it holds otherwise. `pin_o` shows it one cycle later.
- R8: In register mode, the stored bit loads the selected data only in a cycle where the effective clock is 1 and was 0 in the previous cycle. A high level or a falling edge loads nothing.
- R9: While the effective clock enable is 0, neither latch nor register mode changes the stored bit.
- R10: Clock source 0 (and 5..7) selects `ctl_clk_in`, and value n in 1..4 selects `gclk_in[n-1]`. Unselected clock inputs have no effect.
- R11: Enable source 0 (and 5..7) selects `clken_in`, and value n in 1..4 uses `gclk_in[n-1]` as the enable.
- R12: In fixed-level mode, `pin_o` one cycle later equals the configured level regardless of the nets. `pin_en_o` still follows the output enable.
- R13: `local_sel_o` is the local 4:1 result registered one cycle. With the expander on, `exp_sel_in` value 0 picks the own `local_sel_o` and value m in 1..3 picks `exp_in[m-1]`. The expander select adds one register stage, so a select change reaches `pin_o` after two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (R3 layout) |
| net_in | input | 16 | Bank of I/O nets usable as data sources |
| sel0_in | input | 1 | Dynamic select bit 0 |
| sel1_in | input | 1 | Dynamic select bit 1 |
| oe_in | input | 1 | Output enable control |
| ctl_clk_in | input | 1 | Per-cell storage clock |
| clken_in | input | 1 | Per-cell clock enable |
| gclk_in | input | 4 | Global clock lines, also usable as enables |
| exp_sel_in | input | 2 | Expander select |
| exp_in | input | 3 | Local results of three neighbour cells |
| local_sel_o | output | 1 | Registered local 4:1 result for neighbours |
| pin_o | output | 1 | Pin data |
| pin_en_o | output | 1 | Pin drive enable (0 = tri-state) |

## Verification
A corrupted source index or polarity bit makes `pin_o` and `local_sel_o` show the wrong net one cycle after the select inputs settle, so the table of selection patterns exposes it at once. A wrong stored bit, or a lost edge-history bit in register mode, stays hidden while the storage clock is idle. It shows on `pin_o` the cycle after the next capture, or by the absence of a change the cycle after a blocked one. A wrong configured-flag shows as a driven pin before any configuration write. A missing expander stage shows as a one-cycle-early change after a select step.

// File: rtl/xpt_cell_pkg.sv
package xpt_cell_pkg;

  localparam int NUM_SRC  = 4;   // static candidates per cell
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int POL_W    = 5;
  localparam int MODE_W   = 2;
  localparam int CSRC_W   = 3;   // clock / enable source field width
  localparam int NUM_NBR  = 3;   // neighbour results feeding the expander
  localparam int TAIL_W   = POL_W + MODE_W + 2 + 2 * CSRC_W + 1;

  // polarity bit positions inside the polarity field
  localparam int POL_OE  = 0;
  localparam int POL_CLK = 1;
  localparam int POL_EN  = 2;
  localparam int POL_S0  = 3;
  localparam int POL_S1  = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_COMB  = 2'd0,
    MODE_LATCH = 2'd1,
    MODE_REG   = 2'd2,
    MODE_REG2  = 2'd3
  } store_mode_e;

endpackage

// File: rtl/xpt_cfg_reg.sv
module xpt_cfg_reg
  import xpt_cell_pkg::*;
#(
  parameter int SRC_W = 4,
  localparam int IDX_W = NUM_SRC * SRC_W,
  localparam int CFG_W = IDX_W + TAIL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic                  cfg_ok,
  output logic [IDX_W-1:0]      src_idx,
  output logic [POL_W-1:0]      pol,
  output store_mode_e           mode,
  output logic                  jmp_en,
  output logic                  jmp_val,
  output logic [CSRC_W-1:0]     clk_src,
  output logic [CSRC_W-1:0]     en_src,
  output logic                  exp_en
);

  localparam int P_POL  = IDX_W;
  localparam int P_MODE = P_POL + POL_W;
  localparam int P_JEN  = P_MODE + MODE_W;
  localparam int P_JVAL = P_JEN + 1;
  localparam int P_CSRC = P_JVAL + 1;
  localparam int P_ESRC = P_CSRC + CSRC_W;
  localparam int P_XEN  = P_ESRC + CSRC_W;

  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cfg_ok <= 1'b0;
    end else if (cfg_we) begin
      word_q <= cfg_wdata;
      cfg_ok <= 1'b1;
    end
  end

  assign src_idx = word_q[IDX_W-1:0];
  assign pol     = word_q[P_POL +: POL_W];
  assign mode    = store_mode_e'(word_q[P_MODE +: MODE_W]);
  assign jmp_en  = word_q[P_JEN];
  assign jmp_val = word_q[P_JVAL];
  assign clk_src = word_q[P_CSRC +: CSRC_W];
  assign en_src  = word_q[P_ESRC +: CSRC_W];
  assign exp_en  = word_q[P_XEN];

endmodule

// File: rtl/xpt_src_sel.sv
module xpt_src_sel
  import xpt_cell_pkg::*;
#(
  parameter int NUM_NETS = 16,
  parameter int SRC_W    = 4,
  localparam int IDX_W   = NUM_SRC * SRC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_NETS-1:0]  net_in,
  input  logic [IDX_W-1:0]     src_idx,
  input  logic                 sel0_in,
  input  logic                 sel1_in,
  input  logic                 pol_s0,
  input  logic                 pol_s1,
  input  logic                 exp_en,
  input  logic [SEL_W-1:0]     exp_sel_in,
  input  logic [NUM_NBR-1:0]   exp_in,
  output logic                 pick,
  output logic                 loc_q
);

  logic [NUM_SRC-1:0]     cand;
  logic [SEL_W-1:0]       dyn_sel;
  logic                   loc_d;
  logic [SEL_W-1:0]       xsel_q;
  logic [NUM_NBR:0]       wide;

  // static source fetch, one net per candidate slot
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_cand
    logic [SRC_W-1:0] idx;
    assign idx     = src_idx[k*SRC_W +: SRC_W];
    assign cand[k] = net_in[idx];
  end

  assign dyn_sel = {sel1_in ^ pol_s1, sel0_in ^ pol_s0};
  assign loc_d   = cand[dyn_sel];

  // expander stage: own result is registered to align with neighbours
  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q  <= 1'b0;
      xsel_q <= '0;
    end else begin
      loc_q  <= loc_d;
      xsel_q <= exp_sel_in;
    end
  end

  assign wide = {exp_in, loc_q};
  assign pick = exp_en ? wide[xsel_q] : loc_d;

endmodule

// File: rtl/xpt_store.sv
module xpt_store
  import xpt_cell_pkg::*;
#(
  parameter int NUM_GCLK = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  store_mode_e          mode,
  input  logic                 pick,
  input  logic                 ctl_clk_in,
  input  logic                 clken_in,
  input  logic [NUM_GCLK-1:0]  gclk_in,
  input  logic                 pol_clk,
  input  logic                 pol_en,
  input  logic [CSRC_W-1:0]    clk_src,
  input  logic [CSRC_W-1:0]    en_src,
  output logic                 store_next,
  output logic                 eff_en
);

  logic raw_clk;
  logic raw_en;
  logic eff_clk;
  logic clk_prev_q;
  logic stor_q;
  logic rise;

  always_comb begin
    raw_clk = ctl_clk_in;
    raw_en  = clken_in;
    for (int g = 0; g < NUM_GCLK; g++) begin
      if (clk_src == CSRC_W'(g + 1)) raw_clk = gclk_in[g];
      if (en_src  == CSRC_W'(g + 1)) raw_en  = gclk_in[g];
    end
  end

  assign eff_clk = raw_clk ^ pol_clk;
  assign eff_en  = raw_en ^ pol_en;
  assign rise    = eff_clk & ~clk_prev_q;

  always_comb begin
    unique case (mode)
      MODE_COMB:  store_next = pick;
      MODE_LATCH: store_next = (eff_clk & eff_en) ? pick : stor_q;
      default:    store_next = (rise & eff_en) ? pick : stor_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev_q <= 1'b0;
      stor_q     <= 1'b0;
    end else begin
      clk_prev_q <= eff_clk;
      stor_q     <= store_next;
    end
  end

endmodule

// File: rtl/xpt_out_cell.sv
module xpt_out_cell
  import xpt_cell_pkg::*;
#(
  parameter int NUM_NETS = 16,
  parameter int NUM_GCLK = 4,
  localparam int SRC_W   = $clog2(NUM_NETS),
  localparam int IDX_W   = NUM_SRC * SRC_W,
  localparam int CFG_W   = IDX_W + TAIL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [NUM_NETS-1:0]  net_in,
  input  logic                 sel0_in,
  input  logic                 sel1_in,
  input  logic                 oe_in,
  input  logic                 ctl_clk_in,
  input  logic                 clken_in,
  input  logic [NUM_GCLK-1:0]  gclk_in,
  input  logic [SEL_W-1:0]     exp_sel_in,
  input  logic [NUM_NBR-1:0]   exp_in,
  output logic                 local_sel_o,
  output logic                 pin_o,
  output logic                 pin_en_o
);

  logic               cfg_ok;
  logic [IDX_W-1:0]   c_idx;
  logic [POL_W-1:0]   c_pol;
  store_mode_e        c_mode;
  logic               c_jmp_en;
  logic               c_jmp_val;
  logic [CSRC_W-1:0]  c_clk_src;
  logic [CSRC_W-1:0]  c_en_src;
  logic               c_exp_en;
  logic               pick;
  logic               store_next;
  logic               st_eff_en;
  logic               pol_oe;
  logic               pin_q;
  logic               pin_en_q;

  xpt_cfg_reg #(.SRC_W(SRC_W)) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_ok    (cfg_ok),
    .src_idx   (c_idx),
    .pol       (c_pol),
    .mode      (c_mode),
    .jmp_en    (c_jmp_en),
    .jmp_val   (c_jmp_val),
    .clk_src   (c_clk_src),
    .en_src    (c_en_src),
    .exp_en    (c_exp_en)
  );

  xpt_src_sel #(.NUM_NETS(NUM_NETS), .SRC_W(SRC_W)) sel_i (
    .clk        (clk),
    .rst        (rst),
    .net_in     (net_in),
    .src_idx    (c_idx),
    .sel0_in    (sel0_in),
    .sel1_in    (sel1_in),
    .pol_s0     (c_pol[POL_S0]),
    .pol_s1     (c_pol[POL_S1]),
    .exp_en     (c_exp_en),
    .exp_sel_in (exp_sel_in),
    .exp_in     (exp_in),
    .pick       (pick),
    .loc_q      (local_sel_o)
  );

  xpt_store #(.NUM_GCLK(NUM_GCLK)) store_i (
    .clk        (clk),
    .rst        (rst),
    .mode       (c_mode),
    .pick       (pick),
    .ctl_clk_in (ctl_clk_in),
    .clken_in   (clken_in),
    .gclk_in    (gclk_in),
    .pol_clk    (c_pol[POL_CLK]),
    .pol_en     (c_pol[POL_EN]),
    .clk_src    (c_clk_src),
    .en_src     (c_en_src),
    .store_next (store_next),
    .eff_en     (st_eff_en)
  );

  assign pol_oe = c_pol[POL_OE];

  // registered pin stage; drive only after configuration has been loaded
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= 1'b0;
      pin_en_q <= 1'b0;
    end else begin
      pin_q    <= c_jmp_en ? c_jmp_val : store_next;
      pin_en_q <= cfg_ok & (oe_in ^ pol_oe);
    end
  end

  assign pin_o    = pin_q;
  assign pin_en_o = pin_en_q;

endmodule

// File: rtl/xpt_out_cell_chk.sv
module xpt_out_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_ok,
  input logic [1:0] mode,
  input logic       jmp_en,
  input logic       jmp_val,
  input logic       eff_en,
  input logic       oe_in,
  input logic       pol_oe,
  input logic       pin_o,
  input logic       pin_en_o
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!pin_o && !pin_en_o)); // R1

  AST_UNCFG_HIZ: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> !pin_en_o); // R2

  AST_OE_TRACK: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |=> (pin_en_o == ($past(oe_in) ^ $past(pol_oe)))); // R6

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && $past(!jmp_en) && (mode != 2'd0) && !eff_en) |=> $stable(pin_o)); // R9

  AST_FIXED_LEVEL: assert property (@(posedge clk) disable iff (rst)
    jmp_en |=> (pin_o == $past(jmp_val))); // R12

endmodule

bind xpt_out_cell xpt_out_cell_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .cfg_ok   (cfg_ok),
  .mode     (c_mode),
  .jmp_en   (c_jmp_en),
  .jmp_val  (c_jmp_val),
  .eff_en   (st_eff_en),
  .oe_in    (oe_in),
  .pol_oe   (pol_oe),
  .pin_o    (pin_o),
  .pin_en_o (pin_en_o)
);

// File: tb/xpt_out_cell_tb_top.sv
module xpt_out_cell_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NN = 16;
  localparam int NG = 4;
  localparam int CW = 32;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [CW-1:0] cfg_wdata;
  logic [NN-1:0] net_in;
  logic          sel0_in, sel1_in, oe_in, ctl_clk_in, clken_in;
  logic [NG-1:0] gclk_in;
  logic [1:0]    exp_sel_in;
  logic [2:0]    exp_in;
  logic          local_sel_o, pin_o, pin_en_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_out_cell dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .net_in(net_in), .sel0_in(sel0_in), .sel1_in(sel1_in), .oe_in(oe_in),
    .ctl_clk_in(ctl_clk_in), .clken_in(clken_in), .gclk_in(gclk_in),
    .exp_sel_in(exp_sel_in), .exp_in(exp_in),
    .local_sel_o(local_sel_o), .pin_o(pin_o), .pin_en_o(pin_en_o)
  );

  // vector: {pol[4:0], net[15:0], sel1, sel0, oe, exp_data, exp_en}; sources 3,7,9,14
  localparam logic [25:0] VEC [NV] = '{
    {5'h00, 16'h0008, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {5'h00, 16'h0008, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'h00, 16'h0080, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {5'h00, 16'h0200, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {5'h00, 16'h4000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {5'h00, 16'hBFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'h08, 16'h0080, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {5'h10, 16'h0200, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {5'h18, 16'h4000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {5'h18, 16'h4000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'h00, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'h01, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'h01, 16'h0008, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'h1F, 16'h0008, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  // configuration word per the R3 layout
  function automatic logic [CW-1:0] mk_cfg(
      input logic [3:0] i0, input logic [3:0] i1, input logic [3:0] i2, input logic [3:0] i3,
      input logic [4:0] pol, input logic [1:0] mode, input logic jen, input logic jval,
      input logic [2:0] csrc, input logic [2:0] esrc, input logic xen);
    return {xen, esrc, csrc, jval, jen, mode, pol, i3, i2, i1, i0};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [CW-1:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; net_in = '1;
    sel0_in = 1'b0; sel1_in = 1'b0; oe_in = 1'b1; ctl_clk_in = 1'b0;
    clken_in = 1'b1; gclk_in = '0; exp_sel_in = '0; exp_in = '0;
    tick(3);
    chk("R1", "pin_o in reset", pin_o, 1'b0);
    chk("R1", "pin_en_o in reset", pin_en_o, 1'b0);
    chk("R1", "local_sel_o in reset", local_sel_o, 1'b0);
    rst = 1'b0;
    tick(3);
    chk("R2", "pin_en_o unconfigured", pin_en_o, 1'b0);

    // R4 R5 R6 R13 table: combinational selection
    for (int v = 0; v < NV; v++) begin
      write_cfg(mk_cfg(4'd3, 4'd7, 4'd9, 4'd14, VEC[v][25:21], 2'd0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0));
      net_in  = VEC[v][20:5];
      sel1_in = VEC[v][4];
      sel0_in = VEC[v][3];
      oe_in   = VEC[v][2];
      tick(1);
      chk("R4/R5", $sformatf("vec %0d pin_o", v), pin_o, VEC[v][1]);
      chk("R6", $sformatf("vec %0d pin_en_o", v), pin_en_o, VEC[v][0]);
      chk("R13", $sformatf("vec %0d local_sel_o", v), local_sel_o, VEC[v][1]);
    end
    oe_in = 1'b1; sel0_in = 1'b0; sel1_in = 1'b0;

    // R7 latch
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h00, 2'd1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0));
    net_in = 16'h0008; ctl_clk_in = 1'b1; clken_in = 1'b1;
    tick(1); chk("R7", "latch open 1", pin_o, 1'b1);
    net_in = 16'h0000;
    tick(1); chk("R7", "latch open follows 0", pin_o, 1'b0);
    ctl_clk_in = 1'b0; net_in = 16'h0008;
    tick(2); chk("R7", "latch closed holds", pin_o, 1'b0);
    ctl_clk_in = 1'b1; clken_in = 1'b0;
    tick(2); chk("R9", "latch enable low holds", pin_o, 1'b0);
    clken_in = 1'b1;
    tick(1); chk("R7", "latch reopened", pin_o, 1'b1);

    // R8 register
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h00, 2'd2, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0));
    ctl_clk_in = 1'b0; net_in = 16'h0000;
    tick(2); chk("R8", "no edge holds 1", pin_o, 1'b1);
    ctl_clk_in = 1'b1;
    tick(1); chk("R8", "rising edge captures 0", pin_o, 1'b0);
    net_in = 16'h0008;
    tick(2); chk("R8", "high level no capture", pin_o, 1'b0);
    ctl_clk_in = 1'b0;
    tick(1); chk("R8", "falling edge no capture", pin_o, 1'b0);
    ctl_clk_in = 1'b1; clken_in = 1'b0;
    tick(1); chk("R9", "edge with enable low", pin_o, 1'b0);
    ctl_clk_in = 1'b0; clken_in = 1'b1;
    tick(1);
    ctl_clk_in = 1'b1;
    tick(1); chk("R8", "edge captures 1", pin_o, 1'b1);

    // R5 clock polarity: falling input edge captures
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h02, 2'd2, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0));
    net_in = 16'h0000;
    tick(1); chk("R5", "inverted clock idle", pin_o, 1'b1);
    ctl_clk_in = 1'b0;
    tick(1); chk("R5", "inverted clock capture", pin_o, 1'b0);

    // R5 enable polarity
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h04, 2'd2, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0));
    clken_in = 1'b0; ctl_clk_in = 1'b0;
    tick(1);
    net_in = 16'h0008; ctl_clk_in = 1'b1;
    tick(1); chk("R5", "active-low enable captures", pin_o, 1'b1);
    clken_in = 1'b1; ctl_clk_in = 1'b0;
    tick(1);
    net_in = 16'h0000; ctl_clk_in = 1'b1;
    tick(1); chk("R5", "active-low enable blocks", pin_o, 1'b1);

    // R10 global clock source
    clken_in = 1'b1; ctl_clk_in = 1'b0; gclk_in = '0;
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h00, 2'd2, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0));
    tick(1);
    ctl_clk_in = 1'b1;
    tick(1); chk("R10", "unselected clock ignored", pin_o, 1'b1);
    gclk_in[1] = 1'b1;
    tick(1); chk("R10", "global clock 1 captures", pin_o, 1'b0);

    // R11 global line used as enable
    gclk_in = '0; ctl_clk_in = 1'b0;
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h00, 2'd2, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0));
    tick(1);
    net_in = 16'h0008; ctl_clk_in = 1'b1;
    tick(1); chk("R11", "global enable low blocks", pin_o, 1'b0);
    ctl_clk_in = 1'b0; gclk_in[0] = 1'b1; clken_in = 1'b0;
    tick(1);
    ctl_clk_in = 1'b1;
    tick(1); chk("R11", "global enable high captures", pin_o, 1'b1);
    gclk_in = '0; clken_in = 1'b1;

    // R12 fixed level
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h00, 2'd0, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0));
    net_in = 16'h0000;
    tick(1); chk("R12", "fixed high", pin_o, 1'b1);
    chk("R12", "fixed mode keeps enable", pin_en_o, 1'b1);
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h00, 2'd0, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0));
    net_in = 16'hFFFF;
    tick(1); chk("R12", "fixed low", pin_o, 1'b0);

    // R13 expander
    write_cfg(mk_cfg(4'd3, 4'd3, 4'd3, 4'd3, 5'h00, 2'd0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1));
    net_in = 16'h0008; exp_in = 3'b101; exp_sel_in = 2'd0;
    tick(3); chk("R13", "expander own result", pin_o, 1'b1);
    exp_sel_in = 2'd2;
    tick(1); chk("R13", "expander select one cycle", pin_o, 1'b1);
    tick(1); chk("R13", "expander select two cycles", pin_o, 1'b0);
    exp_sel_in = 2'd3;
    tick(2); chk("R13", "expander neighbour 2", pin_o, 1'b1);
    exp_sel_in = 2'd1;
    tick(2); chk("R13", "expander neighbour 0", pin_o, 1'b1);
    exp_in = 3'b100;
    tick(2); chk("R13", "expander neighbour 0 low", pin_o, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule